// File: doc/BRIEF.md
# Dual Redundant DDR Serial Port

This block joins two redundant serial links to one internal byte bus. Each link moves one bit on every edge of its link clock, so a 40 MHz clock gives 80 Mbit/s per link. One link is the primary and the other is the secondary. Only one link is active at a time. The primary is active after reset without any setup, and a select input moves traffic to the secondary.

In the receive direction, the block samples each line on both clock edges. It pairs the two samples into a 2-bit symbol and shifts four symbols into a byte. A one-cycle valid strobe delivers each finished byte to the controller. In the transmit direction, the block takes a byte from the controller with a valid/ready handshake. It sends that byte on the active link as four 2-bit symbols, one per clock cycle. When no byte is waiting, it sends a fixed idle pattern. Bytes in both directions fall into frames of four clock cycles that begin at reset release. A change of the select input takes effect only at the end of a frame.

Top module: `ddr_pair_link`

## Requirements
- R1: While reset is asserted, `rx_valid` is 0, `tx_ready` is 1 and both transmit lines are low. After reset is released, the primary link (select value 0) is the active link.
- R2: Each receive line is sampled on the rising edge and again on the falling edge of `clk`. The two samples form one symbol, with the rising-edge bit first in time and more significant.
- R3: A received byte is four consecutive symbols, most significant symbol first. The first frame begins with the symbol whose rising-edge bit is sampled on the first rising edge after reset release. Each later frame begins four cycles after the one before it.
- R4: `rx_valid` goes high for exactly one cycle, from the first rising edge after the falling-edge bit of a byte's last symbol. `rx_data` holds that byte while `rx_valid` is high.
- R5: A change of `sel` takes effect only at a frame boundary. A byte in progress is completed from the link that was active when the frame began.
- R6: Data on the receive line of the inactive link has no effect on `rx_data`.
- R7: A byte is accepted on a rising edge when `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until the next frame boundary, where the held byte moves into the transmitter.
- R8: A byte that moves into the transmitter at a frame boundary is sent in the next frame on the active link, most significant bit first. Each cycle sends the earlier bit of its pair while `clk` is high and the later bit while `clk` is low.
- R9: The inactive link always sends the idle pattern (parameter `IDLE`, default 8'hC5). The active link also sends the idle pattern in any frame for which no byte was held at the boundary.
- R10: The transmit direction changes link at the same frame boundary as the receive direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; data moves on both edges |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Requested link: 0 primary, 1 secondary |
| pri_rx | input | 1 | Primary link receive line |
| sec_rx | input | 1 | Secondary link receive line |
| pri_tx | output | 1 | Primary link transmit line |
| sec_tx | output | 1 | Secondary link transmit line |
| rx_data | output | BYTE_W | Received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| tx_data | input | BYTE_W | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Block can take a byte |

## Verification
On every cycle, the assertions check these properties:
- The receive strobe lasts a single cycle and comes only at a frame boundary.
- An accepted transmit byte closes `tx_ready`.
- The active link is the primary until the first boundary and changes only at a boundary.

Other behaviour can be shown only by the bench scenarios:
- The bit order on both clock edges.
- MSB-first framing in each direction.
- That the inactive link's data is ignored.
- The idle filler on the active and inactive links.
- That a select change made in the middle of a frame still finishes the current byte from the old link.

// File: rtl/ddr_pair_link.sv
module ddr_pair_link #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] IDLE = 8'hC5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              pri_rx,
  input  logic              sec_rx,
  output logic              pri_tx,
  output logic              sec_tx,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready
);
  localparam int NSYM = BYTE_W / 2;
  localparam int CW = (NSYM > 1) ? $clog2(NSYM) : 1;
  localparam logic [CW-1:0] LAST = CW'(NSYM - 1);

  logic run, active, full;
  logic [CW-1:0] rph;
  logic pri_r, pri_f, sec_r, sec_f;
  logic [BYTE_W-1:0] rx_sh, tx_sh, id_sh, hold;
  logic pri_hi, pri_lo, sec_hi, sec_lo;

  wire bnd  = run && (rph == LAST);
  wire load = !run || bnd;
  wire [1:0] sym   = active ? {sec_r, sec_f} : {pri_r, pri_f};
  wire [1:0] a_sym = tx_sh[BYTE_W-1 -: 2];
  wire [1:0] i_sym = id_sh[BYTE_W-1 -: 2];
  wire take = tx_valid && tx_ready;

  assign tx_ready = !full;
  assign pri_tx = clk ? pri_hi : pri_lo;
  assign sec_tx = clk ? sec_hi : sec_lo;

  // rising-edge capture
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pri_r <= 1'b0;
      sec_r <= 1'b0;
    end else begin
      pri_r <= pri_rx;
      sec_r <= sec_rx;
    end

  // falling-edge capture
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      pri_f <= 1'b0;
      sec_f <= 1'b0;
    end else begin
      pri_f <= pri_rx;
      sec_f <= sec_rx;
    end

  // frame counter and link choice
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run    <= 1'b0;
      rph    <= '0;
      active <= 1'b0;
    end else begin
      run <= 1'b1;
      if (run) rph <= bnd ? '0 : rph + 1'b1;
      if (bnd) active <= sel;
    end

  // receive assembly
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= bnd;
      if (run) rx_sh <= {rx_sh[BYTE_W-3:0], sym};
      if (bnd) rx_data <= {rx_sh[BYTE_W-3:0], sym};
    end

  // transmit holding register
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (take) begin
      full <= 1'b1;
      hold <= tx_data;
    end else if (bnd) begin
      full <= 1'b0;
    end

  // transmit shifters
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh <= '0;
      id_sh <= '0;
    end else if (load) begin
      tx_sh <= (run && full) ? hold : IDLE;
      id_sh <= IDLE;
    end else begin
      tx_sh <= {tx_sh[BYTE_W-3:0], 2'b00};
      id_sh <= {id_sh[BYTE_W-3:0], 2'b00};
    end

  // launch registers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {pri_hi, pri_lo} <= 2'b00;
      {sec_hi, sec_lo} <= 2'b00;
    end else if (run) begin
      {pri_hi, pri_lo} <= active ? i_sym : a_sym;
      {sec_hi, sec_lo} <= active ? a_sym : i_sym;
    end

  assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_rx_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bnd));
  assert_hold_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !tx_ready);
  assert_primary_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !active);
  assert_switch_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active != $past(active)) |-> $past(bnd));
endmodule

// File: tb/ddr_pair_link_bench.sv
`timescale 1ns/1ps
module ddr_pair_link_bench;
  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0;
  logic pri_rx = 1'b0, sec_rx = 1'b0, pri_tx, sec_tx;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic rx_valid, tx_valid = 1'b0, tx_ready;
  int cyc, n_chk = 0, n_bad = 0;
  logic [15:0] pv, sv;

  ddr_pair_link u_ddr_pair_link (.clk, .rst_n, .sel, .pri_rx, .sec_rx, .pri_tx, .sec_tx,
    .rx_data, .rx_valid, .tx_data, .tx_valid, .tx_ready);

  always #5 clk = ~clk;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one frame on both lines; optionally flip sel before symbol flip_at
  task automatic rx_frame(logic [7:0] pb, logic [7:0] sb, int flip_at, logic [7:0] exp, string req);
    do @(negedge clk); while (cyc % 4 != 0);
    for (int k = 0; k < 4; k++) begin
      #2;
      if (k == flip_at) sel = ~sel;
      pri_rx = pb[7-2*k]; sec_rx = sb[7-2*k];
      @(posedge clk); #2;
      pri_rx = pb[6-2*k]; sec_rx = sb[6-2*k];
      @(negedge clk);
    end
    @(posedge clk); #2;
    chk({req, " rx_valid high"}, 16'(rx_valid), 16'd1);
    chk({req, " rx_data"}, 16'(rx_data), 16'(exp));
    @(posedge clk); #2;
    chk("R4 rx_valid single cycle", 16'(rx_valid), 16'd0);
  endtask

  task automatic push(logic [7:0] b);
    do @(negedge clk); while (cyc % 4 != 2);
    chk("R7 tx_ready open", 16'(tx_ready), 16'd1);
    tx_valid = 1'b1; tx_data = b;
    @(posedge clk); #1;
    tx_valid = 1'b0;
    chk("R7 tx_ready closed after accept", 16'(tx_ready), 16'd0);
  endtask

  task automatic grab(output logic [15:0] p, output logic [15:0] s);
    p = '0; s = '0;
    do @(negedge clk); while (cyc % 4 != 2);
    do @(negedge clk); while (cyc % 4 != 1);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #2;
      p = {p[14:0], pri_tx}; s = {s[14:0], sec_tx};
      @(negedge clk); #2;
      p = {p[14:0], pri_tx}; s = {s[14:0], sec_tx};
    end
  endtask

  task automatic t_reset;
    @(posedge clk); #2;
    chk("R1 rx_valid in reset", 16'(rx_valid), 16'd0);
    chk("R1 tx_ready in reset", 16'(tx_ready), 16'd1);
    chk("R1 pri_tx high phase", 16'(pri_tx), 16'd0);
    chk("R1 sec_tx high phase", 16'(sec_tx), 16'd0);
    @(negedge clk); #2;
    chk("R1 pri_tx low phase", 16'(pri_tx), 16'd0);
    chk("R1 sec_tx low phase", 16'(sec_tx), 16'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_rx_primary;
    rx_frame(8'hA7, 8'h3C, -1, 8'hA7, "R1 R2 R3 R6 primary");
    rx_frame(8'h5E, 8'hFF, -1, 8'h5E, "R2 R3 R6 primary");
  endtask

  task automatic t_tx_idle;
    grab(pv, sv);
    chk("R9 active idle", pv, 16'hC5C5);
    chk("R9 inactive idle", sv, 16'hC5C5);
  endtask

  task automatic t_tx_data;
    fork
      begin push(8'h96); push(8'h2D); end
      grab(pv, sv);
    join
    chk("R7 R8 primary bytes", pv, 16'h962D);
    chk("R9 secondary idle", sv, 16'hC5C5);
  endtask

  task automatic t_switch_rx;
    rx_frame(8'h4B, 8'hD2, 2, 8'h4B, "R5 mid-frame switch keeps old link");
    rx_frame(8'h81, 8'h6C, -1, 8'h6C, "R5 R6 secondary active");
  endtask

  task automatic t_switch_tx;
    fork
      begin push(8'h3A); push(8'hE1); end
      grab(pv, sv);
    join
    chk("R10 secondary bytes", sv, 16'h3AE1);
    chk("R9 R10 primary idle", pv, 16'hC5C5);
  endtask

  task automatic t_back_primary;
    sel = 1'b0;
    rx_frame(8'h77, 8'h88, -1, 8'h77, "R5 R6 back to primary");
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rx_primary();
    t_tx_idle();
    t_tx_data();
    t_switch_rx();
    t_switch_tx();
    t_back_primary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule